// File: doc/BRIEF.md
# Block-Ack Transmit Window Tracker

This block keeps per-frame transmit and acknowledgement state for one aggregated transmit queue. It covers a sliding window of up to 64 consecutive 12-bit sequence numbers. When a new frame is accepted it gets the next sequence number and is marked as sent. A block-ack report carries a starting sequence number and a 64-bit bitmap. The report acknowledges the frames it covers. Frames that were sent but are still unacknowledged in the report's range are queued for retransmission, and a frame fails once it has used up its retry budget.

The window start moves forward over leading frames that are finished, meaning acknowledged or failed, and the block emits one completion per cycle in sequence order. Acknowledgements may arrive out of order. A frame acknowledged behind a gap is held until the gap closes. A single-frame in-order mode narrows the window to one outstanding frame, and that frame is retried until it is acknowledged or gives up.

A scheduler uses the block as follows. It offers frames on the send port and takes retransmission requests from the retry port. It forwards each received block-ack report as it arrives and consumes the completion stream.

Top module: `ba_window_tracker`

## Requirements
- R1: After reset the window is empty: `sendSeq` is 0, `retryValid` and `doneValid` are low, and `sendReady` is high whenever the effective window size is non-zero.
- R2: An accepted frame (`sendValid` and `sendReady` high at a clock edge) gets `sendSeq`, which always equals (window start + outstanding count) mod 4096, so accepted frames are numbered consecutively.
- R3: With `cfgInOrder` low, `sendReady` is low exactly when the outstanding count equals min(`cfgWinSize`, 64). A refused offer changes nothing.
- R4: In a report, bitmap bit i refers to sequence (`baSsn` + i) mod 4096, and a set bit acknowledges that frame. Bits that name sequences outside the current window, or frames waiting for retransmission, are ignored.
- R5: A report that leaves a sent, in-window frame unacknowledged queues it for retransmission if its retry count is below `cfgRetryLim`. `retryValid`/`retrySeq` present the pending frame nearest the window start. `retryTaken` while `retryValid` is high marks that frame as sent again and increments its retry count.
- R6: `doneValid` is high exactly when the window-start frame is finished. It then shows `doneSeq` equal to the window start, and the window start advances by one in the next cycle. Finished frames behind an unfinished one are not reported.
- R7: A sent frame that a report leaves unacknowledged after `cfgRetryLim` retransmissions is marked failed, and its completion carries `doneFail` high.
- R8: With `cfgInOrder` high the effective window is one frame, so `sendReady` is high only while nothing is outstanding.
- R9: A report whose start lies numerically above the window start still maps correctly across the 4095-to-0 wrap. For example, start 4090 with bit 6 set acknowledges sequence 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cfgWinSize | input | 7 | Window size in frames (values above 64 act as 64) |
| cfgRetryLim | input | 7 | Retransmissions allowed before a frame fails |
| cfgInOrder | input | 1 | Single-outstanding-frame mode |
| sendValid | input | 1 | Offer of a new frame |
| sendReady | output | 1 | New frame can be accepted |
| sendSeq | output | 12 | Sequence number given to the next accepted frame |
| baValid | input | 1 | Block-ack report present |
| baSsn | input | 12 | Report starting sequence number |
| baBitmap | input | 64 | Report bitmap, bit i for sequence baSsn+i |
| retryValid | output | 1 | A frame awaits retransmission |
| retrySeq | output | 12 | Sequence of the frame to retransmit |
| retryTaken | input | 1 | Retransmission of retrySeq is being sent |
| doneValid | output | 1 | Completion of the window-start frame |
| doneSeq | output | 12 | Sequence of the completed frame |
| doneFail | output | 1 | Completed frame failed |

## Verification
A wrong sent, acknowledged or failed bit in one slot shows up on the ports within a cycle of the next report or window slide. It appears as a retransmission request for an acknowledged frame, a missing request for a lost one, or a completion that comes too early, never comes, or carries the wrong fail flag. A wrong window start or outstanding count changes `sendSeq` and `sendReady` at once, and it offsets every later `doneSeq`. The bench runs a model next to the design and compares all outputs every cycle, so a wrong value is caught in the cycle it first appears.

// File: rtl/bawt_pkg.sv
package bawt_pkg;
  localparam int SEQ_W = 12;
  localparam int WIN   = 64;
  localparam int IDX_W = $clog2(WIN);
  localparam int CNT_W = $clog2(WIN + 1);
  localparam int CFG_W = 7;

  typedef struct packed {
    logic             push;
    logic [IDX_W-1:0] pushIdx;
    logic             pop;
    logic [IDX_W-1:0] popIdx;
    logic             retry;
    logic [IDX_W-1:0] retryIdx;
  } strobe_t;
endpackage

// File: rtl/bawt_slots.sv
module bawt_slots
  import bawt_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  strobe_t            stb,
  input  logic [SEQ_W-1:0]   headSeq,
  input  logic [WIN-1:0]     winMask,
  input  logic               baValid,
  input  logic [SEQ_W-1:0]   baSsn,
  input  logic [WIN-1:0]     baBitmap,
  input  logic [CFG_W-1:0]   cfgRetryLim,
  output logic [WIN-1:0]     doneVec,
  output logic [WIN-1:0]     failVec,
  output logic [WIN-1:0]     pendVec
);
  logic [IDX_W-1:0] headIdx;
  assign headIdx = headSeq[IDX_W-1:0];

  for (genvar s = 0; s < WIN; s++) begin : g_slot
    localparam logic [IDX_W-1:0] SlotIdx = IDX_W'(s);
    logic             sentQ, ackQ, failQ;
    logic [CFG_W-1:0] rtyQ;
    logic [IDX_W-1:0] rel;
    logic [SEQ_W-1:0] slotSeq, rptOff;
    logic             hit, bitSet;

    always_comb begin
      rel     = SlotIdx - headIdx;
      slotSeq = headSeq + SEQ_W'(rel);
      rptOff  = slotSeq - baSsn;
      hit     = baValid && winMask[s] && (rptOff < SEQ_W'(WIN))
                && sentQ && !ackQ && !failQ;
      bitSet  = baBitmap[rptOff[IDX_W-1:0]];
    end

    always_ff @(posedge clk) begin
      if (!rstN || (stb.pop && stb.popIdx == SlotIdx)) begin
        sentQ <= 1'b0;
        ackQ  <= 1'b0;
        failQ <= 1'b0;
        rtyQ  <= '0;
      end else begin
        if (stb.push && stb.pushIdx == SlotIdx) sentQ <= 1'b1;
        if (stb.retry && stb.retryIdx == SlotIdx) begin
          sentQ <= 1'b1;
          rtyQ  <= rtyQ + 1'b1;
        end
        if (hit) begin
          if (bitSet)                   ackQ  <= 1'b1;
          else if (rtyQ >= cfgRetryLim) failQ <= 1'b1;
          else                          sentQ <= 1'b0;
        end
      end
    end

    assign doneVec[s] = ackQ | failQ;
    assign failVec[s] = failQ;
    assign pendVec[s] = winMask[s] & ~sentQ & ~ackQ & ~failQ;
  end
endmodule

// File: rtl/bawt_ctrl.sv
module bawt_ctrl
  import bawt_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  logic [CFG_W-1:0]   cfgWinSize,
  input  logic               cfgInOrder,
  input  logic               sendValid,
  input  logic               retryTaken,
  input  logic [WIN-1:0]     doneVec,
  input  logic [WIN-1:0]     failVec,
  input  logic [WIN-1:0]     pendVec,
  output strobe_t            stb,
  output logic [SEQ_W-1:0]   headSeq,
  output logic [CNT_W-1:0]   count,
  output logic [WIN-1:0]     winMask,
  output logic               sendReady,
  output logic [SEQ_W-1:0]   sendSeq,
  output logic               retryValid,
  output logic [SEQ_W-1:0]   retrySeq,
  output logic               doneValid,
  output logic [SEQ_W-1:0]   doneSeq,
  output logic               doneFail
);
  logic [IDX_W-1:0] headIdx, retryOff;
  logic [CNT_W-1:0] effWin;
  logic             retryHit;

  assign headIdx = headSeq[IDX_W-1:0];

  always_comb begin
    if (cfgInOrder)                      effWin = CNT_W'(1);
    else if (cfgWinSize > CFG_W'(WIN))   effWin = CNT_W'(WIN);
    else                                 effWin = CNT_W'(cfgWinSize);
  end

  for (genvar s = 0; s < WIN; s++) begin : g_mask
    logic [IDX_W-1:0] rel;
    assign rel        = IDX_W'(s) - headIdx;
    assign winMask[s] = CNT_W'(rel) < count;
  end

  always_comb begin
    retryHit = 1'b0;
    retryOff = '0;
    for (int k = WIN - 1; k >= 0; k--) begin
      if (pendVec[headIdx + IDX_W'(k)]) begin
        retryHit = 1'b1;
        retryOff = IDX_W'(k);
      end
    end
  end

  assign sendReady  = count < effWin;
  assign sendSeq    = headSeq + SEQ_W'(count);
  assign retryValid = retryHit;
  assign retrySeq   = headSeq + SEQ_W'(retryOff);
  assign doneValid  = (count != '0) && doneVec[headIdx];
  assign doneSeq    = headSeq;
  assign doneFail   = doneValid && failVec[headIdx];

  always_comb begin
    stb.push     = sendValid && sendReady;
    stb.pushIdx  = sendSeq[IDX_W-1:0];
    stb.pop      = doneValid;
    stb.popIdx   = headIdx;
    stb.retry    = retryTaken && retryHit;
    stb.retryIdx = retrySeq[IDX_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      headSeq <= '0;
      count   <= '0;
    end else begin
      if (stb.pop) headSeq <= headSeq + 1'b1;
      count <= count + CNT_W'(stb.push) - CNT_W'(stb.pop);
    end
  end
endmodule

// File: rtl/ba_window_tracker.sv
module ba_window_tracker
  import bawt_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic [6:0]   cfgWinSize,
  input  logic [6:0]   cfgRetryLim,
  input  logic         cfgInOrder,
  input  logic         sendValid,
  output logic         sendReady,
  output logic [11:0]  sendSeq,
  input  logic         baValid,
  input  logic [11:0]  baSsn,
  input  logic [63:0]  baBitmap,
  output logic         retryValid,
  output logic [11:0]  retrySeq,
  input  logic         retryTaken,
  output logic         doneValid,
  output logic [11:0]  doneSeq,
  output logic         doneFail
);
  strobe_t          stb;
  logic [SEQ_W-1:0] headSeq;
  logic [CNT_W-1:0] count;
  logic [WIN-1:0]   winMask, doneVec, failVec, pendVec;

  bawt_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .cfgWinSize(cfgWinSize), .cfgInOrder(cfgInOrder),
    .sendValid(sendValid), .retryTaken(retryTaken),
    .doneVec(doneVec), .failVec(failVec), .pendVec(pendVec),
    .stb(stb), .headSeq(headSeq), .count(count), .winMask(winMask),
    .sendReady(sendReady), .sendSeq(sendSeq),
    .retryValid(retryValid), .retrySeq(retrySeq),
    .doneValid(doneValid), .doneSeq(doneSeq), .doneFail(doneFail)
  );

  bawt_slots u_slots (
    .clk(clk), .rstN(rstN), .stb(stb), .headSeq(headSeq), .winMask(winMask),
    .baValid(baValid), .baSsn(baSsn), .baBitmap(baBitmap),
    .cfgRetryLim(cfgRetryLim),
    .doneVec(doneVec), .failVec(failVec), .pendVec(pendVec)
  );
endmodule

// File: rtl/bawt_checker.sv
module bawt_checker
  import bawt_pkg::*;
(
  input logic             clk,
  input logic             rstN,
  input logic             cfgInOrder,
  input logic             sendValid,
  input logic             sendReady,
  input logic             retryValid,
  input logic [SEQ_W-1:0] retrySeq,
  input logic             doneValid,
  input logic             doneFail,
  input logic [SEQ_W-1:0] headSeq,
  input logic [CNT_W-1:0] count
);
  a_r3_no_overflow: assert property (@(posedge clk) disable iff (!rstN)
    count <= CNT_W'(WIN));

  a_r3_ready_below_full: assert property (@(posedge clk) disable iff (!rstN)
    sendReady |-> count < CNT_W'(WIN));

  a_r8_inorder_single: assert property (@(posedge clk) disable iff (!rstN)
    (cfgInOrder && sendReady) |-> count == '0);

  a_r6_slide_one: assert property (@(posedge clk) disable iff (!rstN)
    doneValid |=> headSeq == SEQ_W'($past(headSeq) + 1'b1));

  a_r2_count_grows: assert property (@(posedge clk) disable iff (!rstN)
    (sendValid && sendReady && !doneValid) |=> count == CNT_W'($past(count) + 1'b1));

  a_r5_retry_in_window: assert property (@(posedge clk) disable iff (!rstN)
    retryValid |-> (SEQ_W'(retrySeq - headSeq) < SEQ_W'(count)));

  a_r7_fail_has_done: assert property (@(posedge clk) disable iff (!rstN)
    doneFail |-> doneValid);
endmodule

bind ba_window_tracker bawt_checker u_chk (
  .clk(clk), .rstN(rstN), .cfgInOrder(cfgInOrder), .sendValid(sendValid),
  .sendReady(sendReady), .retryValid(retryValid), .retrySeq(retrySeq),
  .doneValid(doneValid), .doneFail(doneFail), .headSeq(headSeq), .count(count)
);

// File: tb/ba_window_tracker_bench.sv
module ba_window_tracker_bench;
  logic        clk = 1'b0;
  logic        rstN;
  logic [6:0]  cfgWinSize, cfgRetryLim;
  logic        cfgInOrder;
  logic        sendValid, baValid, retryTaken;
  logic [11:0] baSsn;
  logic [63:0] baBitmap;
  logic        sendReady, retryValid, doneValid, doneFail;
  logic [11:0] sendSeq, retrySeq, doneSeq;

  int total = 0;
  int bad = 0;

  int mHead, mCnt;
  bit mSent[64], mAck[64], mFail[64];
  int mRty[64];

  always #4 clk = ~clk;

  ba_window_tracker u_ba_window_tracker (
    .clk(clk), .rstN(rstN), .cfgWinSize(cfgWinSize), .cfgRetryLim(cfgRetryLim),
    .cfgInOrder(cfgInOrder), .sendValid(sendValid), .sendReady(sendReady),
    .sendSeq(sendSeq), .baValid(baValid), .baSsn(baSsn), .baBitmap(baBitmap),
    .retryValid(retryValid), .retrySeq(retrySeq), .retryTaken(retryTaken),
    .doneValid(doneValid), .doneSeq(doneSeq), .doneFail(doneFail)
  );

  task automatic chkEq(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int effWin();
    if (cfgInOrder) return 1;
    return (cfgWinSize > 64) ? 64 : int'(cfgWinSize);
  endfunction

  // compare all outputs against the model, then advance model and clock
  task automatic step();
    int h, eRk, i, off;
    bit eR, eD, push;
    #1;
    h = mHead & 63;
    chkEq("R3 sendReady", sendReady, int'(mCnt < effWin()));
    chkEq("R2 sendSeq", sendSeq, (mHead + mCnt) & 4095);
    eR = 0; eRk = 0;
    for (int k = mCnt - 1; k >= 0; k--) begin
      i = (mHead + k) & 63;
      if (!mSent[i] && !mAck[i] && !mFail[i]) begin eR = 1; eRk = k; end
    end
    chkEq("R5 retryValid", retryValid, int'(eR));
    if (eR) chkEq("R5 retrySeq", retrySeq, (mHead + eRk) & 4095);
    eD = (mCnt > 0) && (mAck[h] || mFail[h]);
    chkEq("R6 doneValid", doneValid, int'(eD));
    if (eD) begin
      chkEq("R6 doneSeq", doneSeq, mHead);
      chkEq("R7 doneFail", doneFail, int'(mFail[h]));
    end
    if (baValid) begin
      for (int k = 0; k < mCnt; k++) begin
        i = (mHead + k) & 63;
        off = (mHead + k - int'(baSsn)) & 4095;
        if (off < 64 && mSent[i] && !mAck[i] && !mFail[i]) begin
          if (baBitmap[off])               mAck[i] = 1;
          else if (mRty[i] >= cfgRetryLim) mFail[i] = 1;
          else                             mSent[i] = 0;
        end
      end
    end
    if (retryTaken && eR) begin
      i = (mHead + eRk) & 63;
      mSent[i] = 1;
      mRty[i]++;
    end
    push = sendValid && (mCnt < effWin());
    if (push) mSent[(mHead + mCnt) & 63] = 1;
    if (eD) begin
      mSent[h] = 0; mAck[h] = 0; mFail[h] = 0; mRty[h] = 0;
      mHead = (mHead + 1) & 4095;
    end
    mCnt = mCnt + int'(push) - int'(eD);
    @(negedge clk);
    sendValid = 0; baValid = 0; retryTaken = 0;
  endtask

  task automatic report(input int ssn, input logic [63:0] bm);
    baValid = 1; baSsn = 12'(ssn); baBitmap = bm;
    step();
  endtask

  initial begin
    #(8 * 150000);
    bad++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    rstN = 0; cfgWinSize = 7'd4; cfgRetryLim = 7'd1; cfgInOrder = 0;
    sendValid = 0; baValid = 0; retryTaken = 0; baSsn = '0; baBitmap = '0;
    mHead = 0; mCnt = 0;
    for (int k = 0; k < 64; k++) begin mSent[k] = 0; mAck[k] = 0; mFail[k] = 0; mRty[k] = 0; end
    repeat (3) @(posedge clk);
    @(negedge clk); rstN = 1;
    #1;
    chkEq("R1 sendReady", sendReady, 1);
    chkEq("R1 sendSeq", sendSeq, 0);
    chkEq("R1 retryValid", retryValid, 0);
    chkEq("R1 doneValid", doneValid, 0);
    @(negedge clk);

    // R9: report start 4090, bit 6 covers sequence 0
    sendValid = 1; step();
    report(4090, 64'h40);
    #1; chkEq("R9 doneValid", doneValid, 1); chkEq("R9 doneSeq", doneSeq, 0);
    step();

    // R3: window of 4 fills after 4 offers, fifth refused
    for (int n = 0; n < 5; n++) begin sendValid = 1; step(); end
    #1; chkEq("R3 full", sendReady, 0); chkEq("R3 seq held", sendSeq, 5);

    // R4/R5/R6: seq 2,4 acked, 1,3 lost; bit 40 names a sequence outside the window
    report(1, 64'h0000_0100_0000_000A);
    #1; chkEq("R6 gap holds", doneValid, 0);
    chkEq("R5 earliest", retrySeq, 1);
    retryTaken = 1; step();
    #1; chkEq("R5 next", retrySeq, 3);
    retryTaken = 1; step();
    #1; chkEq("R5 drained", retryValid, 0);

    // R7: seq 1 lost again at limit 1 -> fails; seq 3 acked
    report(1, 64'h4);
    #1; chkEq("R7 done", doneValid, 1); chkEq("R7 fail", doneFail, 1); chkEq("R7 seq", doneSeq, 1);
    step();
    #1; chkEq("R6 next seq", doneSeq, 2); chkEq("R6 not fail", doneFail, 0);
    step(); step(); step();
    #1; chkEq("R6 empty ready", sendReady, 1);

    // R4: all-ones report while seq 6 is being pushed leaves seq 6 unacked
    sendValid = 1; step();
    sendValid = 1; report(5, 64'hFFFF_FFFF_FFFF_FFFF);
    #1; chkEq("R4 seq5 done", doneSeq, 5);
    step();
    #1; chkEq("R4 seq6 untouched", doneValid, 0); chkEq("R4 no retry", retryValid, 0);
    report(6, 64'h1); step();

    // R8: in-order mode
    cfgInOrder = 1;
    sendValid = 1; step();
    #1; chkEq("R8 single", sendReady, 0);
    report(7, 64'h0);
    retryTaken = 1; step();
    report(7, 64'h1);
    #1; chkEq("R8 done seq", doneSeq, 7);
    step();
    cfgInOrder = 0;

    // random phase
    cfgWinSize = 7'd40; cfgRetryLim = 7'd2;
    for (int n = 0; n < 4000; n++) begin
      sendValid  = ($urandom_range(0, 9) < 6);
      retryTaken = ($urandom_range(0, 1) == 1);
      if ($urandom_range(0, 9) < 2) begin
        baValid  = 1;
        baSsn    = 12'((mHead + int'($urandom_range(0, 10)) + 4090) & 4095);
        baBitmap = {$urandom, $urandom};
      end
      step();
    end
    // drain
    for (int n = 0; n < 600 && mCnt > 0; n++) begin
      retryTaken = 1;
      report(mHead, 64'hFFFF_FFFF_FFFF_FFFF);
    end
    #1; chkEq("R6 drained", doneValid, 0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule